// File: doc/BRIEF.md
# Early/Late Bang-Bang Phase Decider

This block makes one timing decision per received bit for a clock and data recovery loop. Three samples of the incoming serial stream are presented together with a valid strobe. Two of them are data-centre samples, taken on consecutive recovered-clock edges (`smp_first_i` and `smp_last_i`). The third is an edge sample, taken on the quadrature clock halfway between them (`smp_mid_i`). From these three bits the block decides whether the recovered clock is late, is early, or saw no data transition.

Each decision is registered and shown for exactly one clock cycle. The output is three-valued: a raise pulse, a lower pulse, or nothing. A long run of identical bits therefore does not leave the loop pushed in one direction. A mismatch pattern in which the edge sample differs from both data samples cannot be resolved, so it is dropped. The loop is locked when data transitions fall on the edge sample, which puts the data samples at the centre of the eye.

An optional saturating signed counter sums the decisions as votes. It is enabled by the `ACC_EN` parameter, and its limits are set by the `ACC_MAX` and `ACC_MIN` parameters. It can feed a digital loop filter directly.

Top module: `bbpd_decider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `up_o`, `dn_o` and `hold_o` are 0 and `vote_o` is 0.
- R2: A strobe whose first sample differs from the mid sample, and whose mid sample equals the last sample (clock late), gives `up_o`=1 in the cycle after the sampling edge.
- R3: A strobe whose first sample equals the mid sample, and whose mid sample differs from the last sample (clock early), gives `dn_o`=1 in the cycle after the sampling edge.
- R4: A strobe whose three samples are equal gives `hold_o`=1, with `up_o`=0 and `dn_o`=0, in the cycle after the sampling edge.
- R5: A strobe with patterns 010 or 101 (first, mid, last) gives `up_o`, `dn_o` and `hold_o` all 0, and leaves `vote_o` unchanged.
- R6: A decision output is high only in the single cycle that follows a clock edge at which `smp_vld_i` was 1. After a cycle with no strobe, all three outputs are 0.
- R7: At most one of `up_o`, `dn_o` and `hold_o` is 1 in any cycle.
- R8: With `ACC_EN`=1, `vote_o` rises by 1 with each `up_o` pulse and falls by 1 with each `dn_o` pulse. It changes in the same cycle the pulse appears, and it does not change otherwise.
- R9: `vote_o` never rises above `ACC_MAX` or falls below `ACC_MIN`. A pulse that arrives at a limit is still emitted, but the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | The three samples are valid this cycle |
| smp_first_i | input | 1 | Data sample on the earlier recovered-clock edge |
| smp_mid_i | input | 1 | Edge sample on the quadrature clock |
| smp_last_i | input | 1 | Data sample on the later recovered-clock edge |
| up_o | output | 1 | Clock late: raise the control, one cycle |
| dn_o | output | 1 | Clock early: lower the control, one cycle |
| hold_o | output | 1 | No transition was seen, one cycle |
| vote_o | output | ACC_W | Signed saturating vote total |

## Verification
The decision pulse and the vote-limit clamp can occur in the same cycle. This happens when a raise or lower decision arrives while the counter already sits at `ACC_MAX` or `ACC_MIN`. The bench provokes it with more late patterns in a row than the upper limit allows, and then more early patterns than the lower limit allows. In each of those cycles the scoreboard expects the pulse to still appear while the count stays at the limit. Invalid and idle cycles are placed between these runs, to show that neither kind moves the count.

// File: rtl/bbpd_decider.sv
`timescale 1ns/1ps
module bbpd_decider #(
  parameter int ACC_W   = 8,
  parameter bit ACC_EN  = 1'b1,
  parameter int ACC_MAX = 100,
  parameter int ACC_MIN = -100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld_i,
  input  logic                    smp_first_i,
  input  logic                    smp_mid_i,
  input  logic                    smp_last_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic                    hold_o,
  output logic signed [ACC_W-1:0] vote_o
);

  logic lead_chg, tail_chg;
  logic late_w, early_w, flat_w;

  assign lead_chg = smp_first_i ^ smp_mid_i;
  assign tail_chg = smp_mid_i ^ smp_last_i;
  assign late_w   = smp_vld_i &  lead_chg & ~tail_chg;
  assign early_w  = smp_vld_i & ~lead_chg &  tail_chg;
  assign flat_w   = smp_vld_i & ~lead_chg & ~tail_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_o   <= 1'b0;
      dn_o   <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      up_o   <= late_w;
      dn_o   <= early_w;
      hold_o <= flat_w;
    end
  end

  generate
    if (ACC_EN) begin : g_vote
      localparam logic signed [ACC_W-1:0] VOTE_HI = ACC_W'(ACC_MAX);
      localparam logic signed [ACC_W-1:0] VOTE_LO = ACC_W'(ACC_MIN);

      always_ff @(posedge clk) begin
        if (!rst_n)
          vote_o <= '0;
        else if (late_w && vote_o != VOTE_HI)
          vote_o <= vote_o + ACC_W'(1);
        else if (early_w && vote_o != VOTE_LO)
          vote_o <= vote_o - ACC_W'(1);
      end

      // R8
      vote_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_o |-> (vote_o == $past(vote_o) + ACC_W'(1)) || ($past(vote_o) == VOTE_HI));
      // R8
      vote_step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_o |-> (vote_o == $past(vote_o) - ACC_W'(1)) || ($past(vote_o) == VOTE_LO));
      // R8
      vote_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_o && !dn_o) |-> $stable(vote_o));
      // R9
      vote_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_o <= VOTE_HI) && (vote_o >= VOTE_LO));
    end else begin : g_novote
      assign vote_o = '0;
    end
  endgenerate

  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_o, dn_o, hold_o}));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> !(up_o || dn_o || hold_o));
  // R5
  drop_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && (smp_first_i != smp_mid_i) && (smp_mid_i != smp_last_i))
      |=> !(up_o || dn_o || hold_o));
  // R2
  late_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && (smp_first_i != smp_mid_i) && (smp_mid_i == smp_last_i)) |=> up_o);
  // R3
  early_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && (smp_first_i == smp_mid_i) && (smp_mid_i != smp_last_i)) |=> dn_o);

endmodule

// File: tb/bbpd_decider_tb_top.sv
`timescale 1ns/1ps
module bbpd_decider_tb_top;
  localparam int W  = 8;
  localparam int HI = 5;
  localparam int LO = -4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
  logic up, dn, hold;
  logic signed [W-1:0] vote;

  always #4 clk = ~clk;

  bbpd_decider #(.ACC_W(W), .ACC_EN(1'b1), .ACC_MAX(HI), .ACC_MIN(LO)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(vld),
    .smp_first_i(s0), .smp_mid_i(s1), .smp_last_i(s2),
    .up_o(up), .dn_o(dn), .hold_o(hold), .vote_o(vote));

  typedef struct {
    logic   eu, ed, ef;
    int     ev;
    string  tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int mdl = 0;
  bit done = 1'b0;

  task automatic drive(input logic v, input logic a, input logic b, input logic c);
    exp_t e;
    logic lc, tc;
    @(negedge clk);
    vld = v; s0 = a; s1 = b; s2 = c;
    lc = a ^ b; tc = b ^ c;
    e.eu = v & lc & ~tc;
    e.ed = v & ~lc & tc;
    e.ef = v & ~lc & ~tc;
    if (!v)                   e.tag = "R6 R7 R8";
    else if (lc && tc)        e.tag = "R5 R7";
    else if (e.ef)            e.tag = "R4 R7 R8";
    else if (e.eu && mdl == HI) e.tag = "R9 R2";
    else if (e.ed && mdl == LO) e.tag = "R9 R3";
    else if (e.eu)            e.tag = "R2 R8";
    else                      e.tag = "R3 R8";
    if (e.eu && mdl < HI) mdl++;
    if (e.ed && mdl > LO) mdl--;
    e.ev = mdl;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (up !== e.eu || dn !== e.ed || hold !== e.ef || int'(vote) != e.ev) begin
        errors++;
        $display("FAIL %s: got up=%0b dn=%0b hold=%0b vote=%0d, expected up=%0b dn=%0b hold=%0b vote=%0d",
                 e.tag, up, dn, hold, vote, e.eu, e.ed, e.ef, e.ev);
      end
    end
  end

  task automatic chk_reset();
    checks++;
    if (up !== 1'b0 || dn !== 1'b0 || hold !== 1'b0 || vote !== '0) begin
      errors++;
      $display("FAIL R1: got up=%0b dn=%0b hold=%0b vote=%0d, expected all 0",
               up, dn, hold, vote);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 chk_reset();                                   // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 chk_reset();                   // R1 first cycle after release
    // all eight combinations, R2 R3 R4 R5
    for (int k = 0; k < 8; k++) drive(1'b1, k[2], k[1], k[0]);
    // strobe absent while samples toggle, R6
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    // long run without transitions, R4
    for (int k = 0; k < 4; k++) drive(1'b1, 1'b1, 1'b1, 1'b1);
    // late run past upper limit with a mismatch in between, R9 R5
    for (int k = 0; k < 8; k++) drive(1'b1, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    // early run past lower limit, R9 R3
    for (int k = 0; k < 12; k++) drive(1'b1, k[0], k[0], ~k[0]);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1);
    // recovery off the lower limit, R8
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule